// File: doc/BRIEF.md
# Multi-Master Arbitration Unit

This block sits inside a serial two-wire bus master and handles contention with other masters on the shared data line. When a transfer starts it loads a byte. It then puts one bit on the open-drain data line in each clock period, most significant bit first, by pulling the line low for a 0 and releasing it for a 1. While the clock is high it compares the bit it meant to send with the level resolved on the bus. If it released the line and still sees it low, another master has won. The unit then stops driving data at once, so the winner's bits pass through intact. Bits that match raise no conflict, so contention can carry on through address and data bytes.

After a loss the unit keeps counting clock periods to the end of the byte, so its byte-done pulse still lines up with the bus. It also requests an immediate switch to slave receive, because the winner may be addressing this node. The lost flag is sticky until software clears it or the next transfer starts. Both bus levels pass through a synchroniser before use. A data-line edge seen while the clock is high during a byte means a foreign START or STOP has collided with a data bit. The unit treats this as an illegal bus sequence: it flags an error, releases the line and abandons the byte.

Top module: `bus_arb_unit`

## Requirements
- R1: While a byte is being sent and arbitration is not lost, `sda_pull_o` is 1 exactly when the current bit is 0. Bits go out MSB first, and the next bit appears after each synchronised SCL falling edge.
- R2: Arbitration is lost only on a sample taken while synchronised SCL is high and `scl_hi_i` is 1, when the current bit is 1 and synchronised SDA is 0. A high phase with `scl_hi_i` held at 0 cannot cause a loss.
- R3: Once arbitration is lost, `sda_pull_o` stays 0 for the rest of the byte, including for later 0 bits.
- R4: `byte_done_o` is a single-cycle pulse after the DATA_W-th synchronised SCL falling edge of a byte. It fires whether or not arbitration was lost, and never earlier.
- R5: A competing master that sends the same bits causes no loss, and the transfer completes normally.
- R6: `lost_o` stays 1 until `clear_i` is pulsed or `start_i` begins a new byte. Either one returns it to 0.
- R7: `slave_rx_req_o` is 1 whenever `lost_o` is 1 and 0 otherwise, so the slave-receive switch is requested in the same cycle the loss is flagged.
- R8: `sda_pull_o` never becomes 1 while synchronised SCL is high, apart from right after a `clear_i`.
- R9: During a byte, an SDA change between two consecutive synchronised-SCL-high cycles sets sticky `seq_err_o` (cleared by `start_i` or `clear_i`). It also releases SDA and abandons the byte, so no `byte_done_o` follows. The same SDA change while idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load `tx_byte_i` and begin a byte (given while SCL is low) |
| tx_byte_i | input | DATA_W | Byte to send |
| clear_i | input | 1 | Clear the lost and sequence-error flags |
| scl_i | input | 1 | Resolved SCL bus level, asynchronous |
| sda_i | input | 1 | Resolved SDA bus level, asynchronous |
| scl_hi_i | input | 1 | Sample qualifier for the SCL high phase from the clock generator |
| sda_pull_o | output | 1 | Open-drain pull-low enable for SDA |
| lost_o | output | 1 | Arbitration lost, sticky |
| byte_done_o | output | 1 | End-of-byte pulse |
| slave_rx_req_o | output | 1 | Request to switch to slave receive |
| seq_err_o | output | 1 | Illegal START/STOP during a data bit, sticky |

## Verification
The bench builds the unit with DATA_W = 4 and two synchroniser stages. With a byte this narrow, every pair of own byte and competitor byte (256 pairings) fits in a short run. The competitor is modelled as a second arbitrating master on a wired-AND bus, so every first-difference position and every tie is covered. A further sweep over all 16 per-bit patterns of the SCL-high qualifier pins down where a loss can and cannot occur. Directed sequences then inject a START edge into a data bit, and the same edge while the bus is idle.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  localparam int unsigned SYNC_MIN = 2;

  typedef struct packed {
    logic sample;    // one qualified sample per SCL high phase
    logic scl_fall;  // synchronised SCL high->low
    logic bus_cond;  // SDA moved while SCL stayed high
  } phase_ev_t;
endpackage

// File: rtl/bus_arb_sync.sv
module bus_arb_sync #(
  parameter int unsigned WIDTH   = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned DEPTH =
    (STAGES < bus_arb_pkg::SYNC_MIN) ? bus_arb_pkg::SYNC_MIN : STAGES;

  logic [DEPTH-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= {DEPTH{RST_VAL}};
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < DEPTH; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[DEPTH-1];
endmodule

// File: rtl/bus_arb_phase.sv
module bus_arb_phase
  import bus_arb_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      scl_i,
  input  logic      sda_i,
  input  logic      scl_hi_i,
  output phase_ev_t ev_o
);
  logic scl_q, sda_q, sampled_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      sampled_q <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (!scl_i)          sampled_q <= 1'b0;
      else if (ev_o.sample) sampled_q <= 1'b1;
    end
  end

  always_comb begin
    ev_o.sample   = scl_i && scl_hi_i && !sampled_q;
    ev_o.scl_fall = scl_q && !scl_i;
    ev_o.bus_cond = scl_i && scl_q && (sda_i != sda_q);
  end
endmodule

// File: rtl/bus_arb_shift.sv
module bus_arb_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              shift_i,
  output logic              msb_o,
  output logic              last_o
);
  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '1;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= data_i;
      cnt_q <= '0;
    end else if (shift_i) begin
      sh_q  <= {sh_q[DATA_W-2:0], 1'b1};  // refill with released level
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign msb_o  = sh_q[DATA_W-1];
  assign last_o = (cnt_q == CNT_LAST);
endmodule

// File: rtl/bus_arb_unit.sv
module bus_arb_unit
  import bus_arb_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              clear_i,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              scl_hi_i,
  output logic              sda_pull_o,
  output logic              lost_o,
  output logic              byte_done_o,
  output logic              slave_rx_req_o,
  output logic              seq_err_o
);
  logic [1:0] bus_s;
  logic       scl_s, sda_s;
  phase_ev_t  ev;
  logic       msb, last;
  logic       busy_q, lost_q, err_q, done_q;
  logic       shift, lose, cond_err;

  bus_arb_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b11)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (bus_s)
  );

  assign scl_s = bus_s[1];
  assign sda_s = bus_s[0];

  bus_arb_phase u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_i   (scl_s),
    .sda_i   (sda_s),
    .scl_hi_i(scl_hi_i),
    .ev_o    (ev)
  );

  bus_arb_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (start_i),
    .data_i (tx_byte_i),
    .shift_i(shift),
    .msb_o  (msb),
    .last_o (last)
  );

  assign shift    = busy_q && ev.scl_fall && !start_i;
  assign cond_err = busy_q && ev.bus_cond && !start_i;
  // released a 1 but the bus reads 0: another master owns the line
  assign lose     = busy_q && !lost_q && !err_q && ev.sample && msb && !sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      lost_q <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= shift && last && !cond_err;
      if (start_i)                busy_q <= 1'b1;
      else if (cond_err)          busy_q <= 1'b0;
      else if (shift && last)     busy_q <= 1'b0;
      if (start_i || clear_i)     lost_q <= 1'b0;
      else if (lose)              lost_q <= 1'b1;
      if (start_i || clear_i)     err_q  <= 1'b0;
      else if (cond_err)          err_q  <= 1'b1;
    end
  end

  assign sda_pull_o     = busy_q && !lost_q && !err_q && !msb;
  assign lost_o         = lost_q;
  assign slave_rx_req_o = lost_q;
  assign seq_err_o      = err_q;
  assign byte_done_o    = done_q;
endmodule

// File: rtl/bus_arb_chk.sv
module bus_arb_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic clear_i,
  input logic scl_hi_i,
  input logic scl_s,
  input logic sda_s,
  input logic sda_pull_o,
  input logic lost_o,
  input logic byte_done_o,
  input logic seq_err_o
);
  AST_LOSS_ON_LOW_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lost_o) |-> $past(scl_s && !sda_s && scl_hi_i)); // R2
  AST_NO_PULL_WHEN_LOST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lost_o |-> !sda_pull_o); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_o |=> !byte_done_o); // R4
  AST_LOST_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lost_o && !start_i && !clear_i) |=> lost_o); // R6
  AST_PULL_RISE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sda_pull_o) && !$past(clear_i)) |-> !scl_s); // R8
  AST_ERR_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_err_o |-> !sda_pull_o); // R9
  AST_NO_DONE_ON_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_o |-> !seq_err_o); // R9
endmodule

bind bus_arb_unit bus_arb_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .clear_i    (clear_i),
  .scl_hi_i   (scl_hi_i),
  .scl_s      (scl_s),
  .sda_s      (sda_s),
  .sda_pull_o (sda_pull_o),
  .lost_o     (lost_o),
  .byte_done_o(byte_done_o),
  .seq_err_o  (seq_err_o)
);

// File: tb/bus_arb_unit_tb.sv
module bus_arb_unit_tb;
  localparam int DW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, clr = 1'b0, scl = 1'b1, hi = 1'b0;
  logic [DW-1:0] tx = '0;
  logic oth_pull = 1'b0, glitch = 1'b0;
  logic sda;
  logic pull, lost, done, slv, err;

  int checks = 0, errors = 0, done_seen = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  assign sda = !(pull || oth_pull || glitch);

  bus_arb_unit #(.DATA_W(DW), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tx_byte_i(tx),
    .clear_i(clr), .scl_i(scl), .sda_i(sda), .scl_hi_i(hi),
    .sda_pull_o(pull), .lost_o(lost), .byte_done_o(done),
    .slave_rx_req_o(slv), .seq_err_o(err)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n);
    repeat (n) begin
      @(negedge clk);
      if (done) done_seen++;
    end
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic xfer(logic [DW-1:0] own, logic [DW-1:0] oth, logic [DW-1:0] qual);
    bit lost_e = 0, oth_lost = 0, bus;
    logic p0;
    done_seen = 0;
    scl = 1'b0; hi = 1'b0; tick(6);
    tx = own; start = 1'b1; oth_pull = !oth[DW-1]; tick(1);
    start = 1'b0; tick(1);
    chk("R6 start clears lost", int'(lost), 0);
    for (int i = DW - 1; i >= 0; i--) begin
      oth_pull = !oth_lost && !oth[i];
      tick(8);
      chk(lost_e ? "R3 pull after loss" : "R1 bit drive", int'(pull), int'(!lost_e && !own[i]));
      scl = 1'b1; hi = qual[i]; tick(1);
      p0 = pull; tick(7);
      chk("R8 pull stable in high", int'(pull), int'(p0));
      bus = (lost_e ? 1'b1 : own[i]) & (oth_lost ? 1'b1 : oth[i]);
      if (qual[i] && !lost_e && own[i] && !bus) lost_e = 1;
      if (!oth_lost && oth[i] && !bus) oth_lost = 1;
      chk(lost_e ? "R2 loss" : "R5 no loss", int'(lost), int'(lost_e));
      chk("R7 slave request", int'(slv), int'(lost_e));
      chk("R4 no early done", done_seen, 0);
      scl = 1'b0; hi = 1'b0;
    end
    oth_pull = 1'b0; tick(8);
    chk("R4 done once", done_seen, 1);
    chk("R6 lost sticky", int'(lost), int'(lost_e));
    chk("R3 released at end", int'(pull), 0);
    scl = 1'b1; tick(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(3);
    chk("R1 reset pull", int'(pull), 0);
    chk("R6 reset lost", int'(lost), 0);
    chk("R4 reset done", int'(done), 0);
    chk("R7 reset req", int'(slv), 0);
    chk("R9 reset err", int'(err), 0);

    for (int o = 0; o < (1 << DW); o++) begin
      for (int c = 0; c < (1 << DW); c++) begin
        xfer(DW'(o), DW'(c), '1);
        if (((o + c) % 4) == 0) begin
          clr = 1'b1; tick(1); clr = 1'b0; tick(1);
          chk("R6 clear", int'(lost), 0);
          chk("R7 clear", int'(slv), 0);
        end
      end
    end

    for (int q = 0; q < (1 << DW); q++) xfer('1, '0, DW'(q));

    // R9: START-like edge inside a data bit
    done_seen = 0;
    scl = 1'b0; tick(6);
    tx = 4'b1010; start = 1'b1; tick(1); start = 1'b0; tick(8);
    scl = 1'b1; hi = 1'b1; tick(8);
    chk("R9 no error before edge", int'(err), 0);
    glitch = 1'b1; tick(6);
    chk("R9 error flagged", int'(err), 1);
    scl = 1'b0; hi = 1'b0; tick(2);
    glitch = 1'b0; tick(6);
    chk("R9 released after error", int'(pull), 0);
    for (int i = 0; i < DW - 1; i++) begin
      scl = 1'b1; hi = 1'b1; tick(8);
      scl = 1'b0; hi = 1'b0; tick(8);
      chk("R9 no drive after error", int'(pull), 0);
    end
    chk("R9 byte abandoned", done_seen, 0);
    chk("R9 error sticky", int'(err), 1);
    clr = 1'b1; tick(1); clr = 1'b0; tick(1);
    chk("R9 error cleared", int'(err), 0);

    scl = 1'b1; tick(4);
    glitch = 1'b1; tick(6);
    glitch = 1'b0; tick(6);
    chk("R9 idle edge ignored", int'(err), 0);
    chk("R9 idle no drive", int'(pull), 0);

    report();
  end
endmodule